// File: doc/BRIEF.md
# DSL Transceiver Activation Sequencer

This block is the control state machine that walks a two-wire DSL data pump through its startup training. A strap input selects whether it acts as the master end or the slave end. The block watches strobes from the line-signal detectors: one for the two-level S0 signal and one for the four-level S1 signal. From these it selects what the transmitter sends (silence, S0 or S1), turns the training of the AGC, the echo canceller and the DFE/slicer on and off, and finally raises an ACTIVE flag.

Progress is counted by an activation timer (MAT). The timer advances once per enable tick from a shared prescaler. Programmable thresholds end each timed training stage. When the master hears the slave's first S0, it reloads its timer to a fixed mid-sequence value, so both ends follow the same schedule from then on. After the last timed stage, progress depends only on received signals.

If the timer reaches its programmable limit before the link is up, the attempt is abandoned and a timeout pulse is given. A synchronous deactivate input returns the sequencer to Inactive from any state.

Top module: `dsl_act_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after `deact` is sampled high in any state, the sequencer is Inactive. In Inactive, `tx_sel` is 0 (silent), all training enables are 0, and `active` and `timeout` are 0.
- R2: MAT only changes on a cycle with `tick` high, a reload, or a return to Inactive. An Inactive master leaves Inactive on the first `tick`. It then sends S0 (`tx_sel`=1) with echo-canceller training on. Once MAT exceeds `lim_sig`, it enters signal-detect, still sending S0.
- R3: An Inactive slave that sees `s0_det` starts MAT from 0 and enters a wait stage: silent, AGC training only. Once MAT exceeds `lim_sig`, it sends S0 and enters the echo-canceller stage, with echo-canceller and AGC training on.
- R4: A master in signal-detect that sees `s0_det` loads MAT with `lim_sig`+1 and enters the echo-canceller stage, however long it has waited. A master ignores `s0_det` before signal-detect.
- R5: The echo-canceller stage lasts until MAT exceeds `lim_ec`. The adapt stage that follows sends S0 with echo-canceller training only, until MAT exceeds `lim_adapt`. The hold stage then sends S0 with no training, until MAT exceeds `lim_hold`.
- R6: After the hold stage, the master sends S1 (`tx_sel`=2) and the slave keeps sending S0. Neither end trains. They leave this stage only on `s1_det`.
- R7: On `s1_det`, DFE/slicer training runs for `DFE_TICKS` ticks, while each end keeps sending what it sent in R6. The slave starts sending S1 only after this training is done.
- R8: For mode codes whose upper two bits are not both 1, the sequencer enters Active once DFE training is done. In Active, `active`=1 and S1 is sent. It stays Active when MAT is at or beyond `lim_total`.
- R9: For framed mode codes 6 and 7, after DFE training the sequencer sends S1 with no training and `active`=0 until `frame_sync` is seen, and then enters Active.
- R10: In any state other than Inactive and Active, MAT at or above `lim_total` returns the sequencer to Inactive and gives a one-cycle `timeout` pulse in the first Inactive cycle. The transmitter is silenced, and a master starts a new attempt on the next `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer enable tick from the shared prescaler |
| is_master | input | 1 | Strap: 1 selects the master end, 0 the slave end |
| deact | input | 1 | Synchronous deactivate request |
| mode | input | 3 | Operating mode code; 6 and 7 are framed |
| s0_det | input | 1 | Two-level S0 signal detected on the line |
| s1_det | input | 1 | Four-level S1 signal detected on the line |
| frame_sync | input | 1 | Frame alignment reached (framed modes) |
| lim_sig | input | TW | End of the first timed stage (send / wait) |
| lim_ec | input | TW | End of the echo-canceller stage |
| lim_adapt | input | TW | End of the adapt stage |
| lim_hold | input | TW | End of the hold stage |
| lim_total | input | TW | Activation timer limit |
| tx_sel | output | 2 | Transmit select: 0 silent, 1 S0, 2 S1 |
| trn_agc | output | 1 | AGC training enable |
| trn_ec | output | 1 | Echo-canceller training enable |
| trn_dfe | output | 1 | DFE and four-level slicer training enable |
| active | output | 1 | Link is active |
| timeout | output | 1 | One-cycle pulse on an abandoned attempt |

## Verification
A cycle-level reference model of the requirements runs in lock-step with the design, and every output is compared on every cycle. Stimulus is drawn from episodes with random roles, modes, thresholds, tick densities and detector strobe rates.

Dense S0 strobes show whether a master wrongly reacts before signal-detect. Very sparse ones leave the master sitting in signal-detect for long periods and show whether the reload realigns the timer. Small timer limits separate timeout handling from stage progress. Framed against unframed modes, and rare deactivate strobes, show the two routes to and from Active.

// File: rtl/act_pkg.sv
package act_pkg;

   typedef enum logic [3:0] {
      ST_IDLE   = 4'd0,
      ST_SEND   = 4'd1,
      ST_SIGDET = 4'd2,
      ST_WAIT   = 4'd3,
      ST_EC     = 4'd4,
      ST_ADAPT  = 4'd5,
      ST_HOLD   = 4'd6,
      ST_LVL4   = 4'd7,
      ST_TRAIN4 = 4'd8,
      ST_FSYNC  = 4'd9,
      ST_ACTIVE = 4'd10
   } act_st_e;

   localparam logic [1:0] TX_OFF = 2'd0;
   localparam logic [1:0] TX_S0  = 2'd1;
   localparam logic [1:0] TX_S1  = 2'd2;

   // number of timer-driven stage boundaries
   localparam int unsigned NUM_STG = 4;
   localparam int unsigned STG_SIG   = 0;
   localparam int unsigned STG_EC    = 1;
   localparam int unsigned STG_ADAPT = 2;
   localparam int unsigned STG_HOLD  = 3;

   typedef struct packed {
      logic [1:0] tx;
      logic       agc;
      logic       ec;
      logic       dfe;
      logic       act;
   } act_out_t;

   function automatic act_out_t act_decode(act_st_e st, logic master);
      act_out_t o;
      o = '{tx: TX_OFF, agc: 1'b0, ec: 1'b0, dfe: 1'b0, act: 1'b0};
      unique case (st)
         ST_SEND, ST_SIGDET: begin o.tx = TX_S0; o.ec = 1'b1; end
         ST_WAIT:            o.agc = 1'b1;
         ST_EC:              begin o.tx = TX_S0; o.ec = 1'b1; o.agc = 1'b1; end
         ST_ADAPT:           begin o.tx = TX_S0; o.ec = 1'b1; end
         ST_HOLD:            o.tx = TX_S0;
         ST_LVL4:            o.tx = master ? TX_S1 : TX_S0;
         ST_TRAIN4:          begin o.tx = master ? TX_S1 : TX_S0; o.dfe = 1'b1; end
         ST_FSYNC:           o.tx = TX_S1;
         ST_ACTIVE:          begin o.tx = TX_S1; o.act = 1'b1; end
         default:            o.tx = TX_OFF;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/act_timer.sv
module act_timer #(
   parameter int unsigned TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   input  logic          tick,
   output logic [TW-1:0] mat
);

   localparam logic [TW-1:0] MAT_MAX = {TW{1'b1}};

   if (TW < 4) begin : g_chk_tw
      $error("act_timer: TW must be at least 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mat <= '0;
      else if (clr)                     mat <= '0;
      else if (load)                    mat <= load_val;
      else if (tick && mat != MAT_MAX)  mat <= mat + 1'b1;
   end

   // R4: a reload lands exactly the requested value
   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (mat == $past(load_val)));

   // R2: the timer does not move without a tick, reload or clear
   p_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !tick) |=> $stable(mat));

endmodule

// File: rtl/act_thr_cmp.sv
module act_thr_cmp #(
   parameter int unsigned TW = 16,
   parameter int unsigned N  = 4
) (
   input  logic [TW-1:0]        mat,
   input  logic [N-1:0][TW-1:0] thr,
   input  logic [TW-1:0]        lim_total,
   output logic [N-1:0]         past,
   output logic                 expired
);

   if (N < 1) begin : g_chk_n
      $error("act_thr_cmp: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_stage
      assign past[i] = (mat > thr[i]);
   end

   assign expired = (mat >= lim_total);

endmodule

// File: rtl/act_train_cnt.sv
module act_train_cnt #(
   parameter int unsigned TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic done
);

   localparam int unsigned CW = $clog2(TICKS + 1);
   localparam logic [CW-1:0] CNT_END = CW'(TICKS);

   if (TICKS < 1) begin : g_chk_ticks
      $error("act_train_cnt: TICKS must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (!run)                     cnt <= '0;
      else if (tick && cnt != CNT_END)   cnt <= cnt + 1'b1;
   end

   assign done = (cnt == CNT_END);

   // R7: the training count never runs past its end
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt <= CNT_END));

   // R7: the count restarts from zero for every training run
   p_cnt_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/act_fsm.sv
module act_fsm
   import act_pkg::*;
#(
   parameter int unsigned N = NUM_STG
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         is_master,
   input  logic         deact,
   input  logic [2:0]   mode,
   input  logic         s0_det,
   input  logic         s1_det,
   input  logic         frame_sync,
   input  logic [N-1:0] past,
   input  logic         expired,
   input  logic         train_done,
   output act_st_e      st,
   output logic         mat_clr,
   output logic         mat_load,
   output logic         train_run,
   output logic         timeout
);

   if (N != NUM_STG) begin : g_chk_n
      $error("act_fsm: stage count must match the package");
   end

   act_st_e nxt;
   logic    to_evt;
   logic    framed;
   logic    timed;

   assign framed = (mode[2:1] == 2'b11);
   assign timed  = (st != ST_IDLE) && (st != ST_ACTIVE);

   always_comb begin
      nxt      = st;
      mat_load = 1'b0;
      to_evt   = 1'b0;
      if (deact) begin
         nxt = ST_IDLE;
      end else if (timed && expired) begin
         nxt    = ST_IDLE;
         to_evt = 1'b1;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (is_master) begin
                  if (tick) nxt = ST_SEND;
               end else if (s0_det) begin
                  nxt = ST_WAIT;
               end
            end
            ST_SEND:   if (past[STG_SIG]) nxt = ST_SIGDET;
            ST_SIGDET: if (s0_det) begin
                          nxt      = ST_EC;
                          mat_load = 1'b1;
                       end
            ST_WAIT:   if (past[STG_SIG])   nxt = ST_EC;
            ST_EC:     if (past[STG_EC])    nxt = ST_ADAPT;
            ST_ADAPT:  if (past[STG_ADAPT]) nxt = ST_HOLD;
            ST_HOLD:   if (past[STG_HOLD])  nxt = ST_LVL4;
            ST_LVL4:   if (s1_det)          nxt = ST_TRAIN4;
            ST_TRAIN4: if (train_done)      nxt = framed ? ST_FSYNC : ST_ACTIVE;
            ST_FSYNC:  if (frame_sync)      nxt = ST_ACTIVE;
            ST_ACTIVE: nxt = ST_ACTIVE;
            default:   nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         timeout <= 1'b0;
      end else begin
         st      <= nxt;
         timeout <= to_evt;
      end
   end

   assign mat_clr   = (st == ST_IDLE);
   assign train_run = (st == ST_TRAIN4);

   // R1: deactivate always lands in Inactive
   p_deact_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      deact |=> (st == ST_IDLE));

   // R8: Active is left only through deactivate
   p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACTIVE && !deact) |=> (st == ST_ACTIVE));

   // R10: the timeout indication lasts a single cycle
   p_timeout_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);

   // R10: a timeout is only reported in Inactive
   p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (st == ST_IDLE));

   // R4: slave S0 in signal-detect moves the master to the echo stage
   p_sigdet_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SIGDET && s0_det && !deact && !expired) |=> (st == ST_EC));

   // R6: four-level detect is left only by S1, timeout or deactivate
   p_lvl4_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LVL4 && !s1_det && !deact && !expired) |=> (st == ST_LVL4));

endmodule

// File: rtl/act_out_dec.sv
module act_out_dec
   import act_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  act_st_e  st,
   input  logic     is_master,
   output act_out_t outs
);

   act_out_t dec;

   assign dec = act_decode(st, is_master);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) outs <= '0;
         else        outs <= dec;
      end
   end else begin : g_comb
      assign outs = dec;
   end

   // R7: DFE training never overlaps timed S0-stage training
   p_dfe_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      outs.dfe |-> (!outs.ec && !outs.agc));

   // R8: active implies the four-level signal is on the line
   p_active_s1_r8: assert property (@(posedge clk) disable iff (!rst_n)
      outs.act |-> (outs.tx == TX_S1));

endmodule

// File: rtl/dsl_act_seq.sv
module dsl_act_seq
   import act_pkg::*;
#(
   parameter int unsigned TW        = 16,
   parameter int unsigned DFE_TICKS = 8,
   parameter bit          OUT_REG   = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          is_master,
   input  logic          deact,
   input  logic [2:0]    mode,
   input  logic          s0_det,
   input  logic          s1_det,
   input  logic          frame_sync,
   input  logic [TW-1:0] lim_sig,
   input  logic [TW-1:0] lim_ec,
   input  logic [TW-1:0] lim_adapt,
   input  logic [TW-1:0] lim_hold,
   input  logic [TW-1:0] lim_total,
   output logic [1:0]    tx_sel,
   output logic          trn_agc,
   output logic          trn_ec,
   output logic          trn_dfe,
   output logic          active,
   output logic          timeout
);

   logic [TW-1:0]               mat;
   logic [NUM_STG-1:0][TW-1:0]  thr;
   logic [NUM_STG-1:0]          past;
   logic [TW-1:0]               resync_val;
   logic                        expired;
   logic                        mat_clr;
   logic                        mat_load;
   logic                        train_run;
   logic                        train_done;
   act_st_e                     st;
   act_out_t                    outs;

   assign thr[STG_SIG]   = lim_sig;
   assign thr[STG_EC]    = lim_ec;
   assign thr[STG_ADAPT] = lim_adapt;
   assign thr[STG_HOLD]  = lim_hold;
   assign resync_val     = lim_sig + 1'b1;

   act_timer #(.TW(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (mat_clr),
      .load     (mat_load),
      .load_val (resync_val),
      .tick     (tick),
      .mat      (mat)
   );

   act_thr_cmp #(.TW(TW), .N(NUM_STG)) i_cmp (
      .mat       (mat),
      .thr       (thr),
      .lim_total (lim_total),
      .past      (past),
      .expired   (expired)
   );

   act_train_cnt #(.TICKS(DFE_TICKS)) i_train (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (train_run),
      .tick  (tick),
      .done  (train_done)
   );

   act_fsm #(.N(NUM_STG)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .is_master  (is_master),
      .deact      (deact),
      .mode       (mode),
      .s0_det     (s0_det),
      .s1_det     (s1_det),
      .frame_sync (frame_sync),
      .past       (past),
      .expired    (expired),
      .train_done (train_done),
      .st         (st),
      .mat_clr    (mat_clr),
      .mat_load   (mat_load),
      .train_run  (train_run),
      .timeout    (timeout)
   );

   act_out_dec #(.OUT_REG(OUT_REG)) i_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .st        (st),
      .is_master (is_master),
      .outs      (outs)
   );

   assign tx_sel  = outs.tx;
   assign trn_agc = outs.agc;
   assign trn_ec  = outs.ec;
   assign trn_dfe = outs.dfe;
   assign active  = outs.act;

   // R2: the master enters signal-detect only after the timer passed lim_sig
   p_sigdet_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SEND && !past[STG_SIG] && !deact) |=> (st != ST_SIGDET));

endmodule

// File: tb/test_dsl_act_seq.sv
`timescale 1ns/1ps
module test_dsl_act_seq;

   localparam int TW  = 16;
   localparam int DFE = 8;

   // reference state codes
   localparam int M_IDLE = 0, M_SEND = 1, M_SIGDET = 2, M_WAIT = 3, M_EC = 4,
                  M_ADAPT = 5, M_HOLD = 6, M_LVL4 = 7, M_TRAIN = 8,
                  M_FSYNC = 9, M_ACT = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          is_master = 1'b0;
   logic          deact = 1'b0;
   logic [2:0]    mode = 3'd0;
   logic          s0_det = 1'b0;
   logic          s1_det = 1'b0;
   logic          frame_sync = 1'b0;
   logic [TW-1:0] lim_sig = 16'd3, lim_ec = 16'd6, lim_adapt = 16'd9;
   logic [TW-1:0] lim_hold = 16'd12, lim_total = 16'd200;
   logic [1:0]    tx_sel;
   logic          trn_agc, trn_ec, trn_dfe, active, timeout;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dsl_act_seq #(.TW(TW), .DFE_TICKS(DFE)) i_dsl_act_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .is_master(is_master),
      .deact(deact), .mode(mode), .s0_det(s0_det), .s1_det(s1_det),
      .frame_sync(frame_sync), .lim_sig(lim_sig), .lim_ec(lim_ec),
      .lim_adapt(lim_adapt), .lim_hold(lim_hold), .lim_total(lim_total),
      .tx_sel(tx_sel), .trn_agc(trn_agc), .trn_ec(trn_ec), .trn_dfe(trn_dfe),
      .active(active), .timeout(timeout)
   );

   // ---------------- reference model of the requirements ----------------
   int m_st = M_IDLE;
   int m_mat = 0;
   int m_cnt = 0;
   bit m_to = 1'b0;

   always @(posedge clk) begin : ref_model
      int ns, nm, nc;
      bit to;
      if (!rst_n) begin
         m_st <= M_IDLE; m_mat <= 0; m_cnt <= 0; m_to <= 1'b0;
      end else begin
         ns = m_st; to = 1'b0;
         // timer (R2, R3, R4)
         if (m_st == M_IDLE)                 nm = 0;
         else if (m_st == M_SIGDET && s0_det) nm = int'(lim_sig) + 1;
         else if (tick)                       nm = m_mat + 1;
         else                                 nm = m_mat;
         // DFE training length (R7)
         if (m_st != M_TRAIN)   nc = 0;
         else if (tick && m_cnt < DFE) nc = m_cnt + 1;
         else                   nc = m_cnt;
         if (deact) ns = M_IDLE;
         else if (m_st != M_IDLE && m_st != M_ACT && m_mat >= int'(lim_total)) begin
            ns = M_IDLE; to = 1'b1;
         end else begin
            case (m_st)
               M_IDLE:   if (is_master ? tick : s0_det) ns = is_master ? M_SEND : M_WAIT;
               M_SEND:   if (m_mat > int'(lim_sig))   ns = M_SIGDET;
               M_SIGDET: if (s0_det)                  ns = M_EC;
               M_WAIT:   if (m_mat > int'(lim_sig))   ns = M_EC;
               M_EC:     if (m_mat > int'(lim_ec))    ns = M_ADAPT;
               M_ADAPT:  if (m_mat > int'(lim_adapt)) ns = M_HOLD;
               M_HOLD:   if (m_mat > int'(lim_hold))  ns = M_LVL4;
               M_LVL4:   if (s1_det)                  ns = M_TRAIN;
               M_TRAIN:  if (m_cnt == DFE) ns = (mode >= 3'd6) ? M_FSYNC : M_ACT;
               M_FSYNC:  if (frame_sync)              ns = M_ACT;
               default:  ns = m_st;
            endcase
         end
         if (ns == M_IDLE && m_st != M_IDLE && !(m_st == M_SIGDET && s0_det)) begin end
         m_st <= ns; m_mat <= nm; m_cnt <= nc; m_to <= to;
      end
   end

   // expected {tx, agc, ec, dfe, active} for a reference state
   function automatic logic [5:0] expect_out(int st, bit master);
      case (st)
         M_SEND, M_SIGDET: return {2'd1, 1'b0, 1'b1, 1'b0, 1'b0};
         M_WAIT:           return {2'd0, 1'b1, 1'b0, 1'b0, 1'b0};
         M_EC:             return {2'd1, 1'b1, 1'b1, 1'b0, 1'b0};
         M_ADAPT:          return {2'd1, 1'b0, 1'b1, 1'b0, 1'b0};
         M_HOLD:           return {2'd1, 1'b0, 1'b0, 1'b0, 1'b0};
         M_LVL4:           return {master ? 2'd2 : 2'd1, 1'b0, 1'b0, 1'b0, 1'b0};
         M_TRAIN:          return {master ? 2'd2 : 2'd1, 1'b0, 1'b0, 1'b1, 1'b0};
         M_FSYNC:          return {2'd2, 1'b0, 1'b0, 1'b0, 1'b0};
         M_ACT:            return {2'd2, 1'b0, 1'b0, 1'b0, 1'b1};
         default:          return 6'd0;
      endcase
   endfunction

   function automatic string tag_of(int st, bit to);
      if (to) return "R10";
      case (st)
         M_IDLE:   return "R1";
         M_SEND:   return "R2";
         M_SIGDET: return "R4";
         M_WAIT:   return "R3";
         M_EC, M_ADAPT, M_HOLD: return "R5";
         M_LVL4:   return "R6";
         M_TRAIN:  return "R7";
         M_FSYNC:  return "R9";
         default:  return "R8";
      endcase
   endfunction

   task automatic compare_now();
      logic [6:0] act_v, exp_v;
      act_v = {tx_sel, trn_agc, trn_ec, trn_dfe, active, timeout};
      exp_v = {expect_out(m_st, is_master), m_to};
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s: outputs {tx,agc,ec,dfe,act,to} actual=%b expected=%b at %0t",
                  tag_of(m_st, m_to), act_v, exp_v, $time);
      end
   endtask

   // one episode of constrained random stimulus
   task automatic run_episode(int ncyc, int tick_den, int s0_den, int s1_den,
                              int fs_den, int deact_den);
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         compare_now();
         tick       = ($urandom % tick_den) == 0;
         s0_det     = ($urandom % s0_den) == 0;
         s1_det     = ($urandom % s1_den) == 0;
         frame_sync = ($urandom % fs_den) == 0;
         deact      = ($urandom % deact_den) == 0;
      end
   endtask

   task automatic force_idle();
      @(negedge clk);
      compare_now();
      deact = 1'b1; tick = 1'b0; s0_det = 1'b0; s1_det = 1'b0; frame_sync = 1'b0;
      @(negedge clk);
      compare_now();
      deact = 1'b0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int dummy;
      dummy = $urandom(32'd20240611);
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if ({tx_sel, trn_agc, trn_ec, trn_dfe, active, timeout} !== 7'd0) begin
         errors++;
         $display("FAIL R1: reset outputs actual=%b expected=%b",
                  {tx_sel, trn_agc, trn_ec, trn_dfe, active, timeout}, 7'd0);
      end
      rst_n = 1'b1;

      // directed: master, ticks every cycle, slave S0 arrives very late (R4)
      is_master = 1'b1; mode = 3'd0;
      lim_sig = 16'd2; lim_ec = 16'd5; lim_adapt = 16'd7; lim_hold = 16'd9;
      lim_total = 16'd400;
      force_idle();
      run_episode(200, 1, 1000000, 1000000, 2, 1000000);
      run_episode(300, 1, 2, 4, 2, 1000000);

      // directed: slave, framed mode, one-tick thresholds (R3, R9)
      is_master = 1'b0; mode = 3'd7;
      lim_sig = 16'd0; lim_ec = 16'd1; lim_adapt = 16'd2; lim_hold = 16'd3;
      lim_total = 16'd100;
      force_idle();
      run_episode(300, 2, 4, 8, 30, 1000000);

      // directed: master timeout at the limit with no partner (R10)
      is_master = 1'b1; mode = 3'd1;
      lim_sig = 16'd3; lim_ec = 16'd6; lim_adapt = 16'd8; lim_hold = 16'd10;
      lim_total = 16'd12;
      force_idle();
      run_episode(200, 1, 1000000, 1000000, 2, 1000000);

      // random episodes
      for (int e = 0; e < 90; e++) begin
         is_master = 1'($urandom % 2);
         mode      = 3'($urandom % 8);
         lim_sig   = 16'($urandom % 6);
         lim_ec    = lim_sig + 16'(1 + $urandom % 6);
         lim_adapt = lim_ec + 16'(1 + $urandom % 6);
         lim_hold  = lim_adapt + 16'(1 + $urandom % 6);
         lim_total = (($urandom % 4) == 0) ? 16'(1 + $urandom % (int'(lim_hold) + 4))
                                           : 16'(200 + $urandom % 50);
         force_idle();
         run_episode(400, 1 + $urandom % 3, (($urandom % 3) == 0) ? 200 : 6,
                     4 + $urandom % 20, 3 + $urandom % 30,
                     (($urandom % 2) == 0) ? 700 : 1000000);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule